// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Port

This block is the programming front end of a frequency synthesizer. An external controller shifts setting words in over a slow serial link made of a data line, a serial clock and an active-low load strobe. A fourth line, the write select, decides which register takes the bits. With the select low, bits go into a 20-bit primary word. With it high, bits go into an 8-bit enhancement word. When the load strobe rises, the whole primary word is copied into a 20-bit secondary word. The divider setting can therefore be staged in the background and switched over in one step.

A live frequency-select input chooses whether the primary or the secondary word drives the divider-setting bus. An active-low mode input enables the enhancement word. Outside that mode, the enhancement outputs and the serial data-out pin are held at zero. All serial pins are asynchronous to the system clock. Each pin passes through the same two-flop synchronizer, and edges are found from the synchronized history. The link must hold each serial clock level for at least three system clocks.

Top module: `synth_cfg_port`

## Requirements
- R1: Serial bits enter most significant bit first. Each new bit enters at bit 0 and the older bits move one place toward the MSB, so after 20 shifts the first bit sent sits in bit 19.
- R2: Exactly one bit is captured for each rising edge of `ser_clk`, and no register changes without such an edge. Every pin is seen through a two-flop synchronizer. A pin change that lands before clock edge k moves an output mux after edge k+1 and a shift register after edge k+2.
- R3: With `enh_wr` low, a serial clock edge shifts the primary word and leaves the enhancement word unchanged. With `enh_wr` high, it shifts the enhancement word and leaves the primary word unchanged.
- R4: The primary word shifts only while `load_n` is low. While `load_n` is high, serial clock edges leave the primary word unchanged.
- R5: On a rising edge of `load_n`, the secondary word takes the whole primary word. At all other times the secondary word holds its value.
- R6: `div_word` shows the primary word when `freq_sel` is 1 and the secondary word when `freq_sel` is 0.
- R7: `enh_bits` shows the enhancement word only while `enh_mode_n` is 0. While `enh_mode_n` is 1, `enh_bits` is all zeros.
- R8: `dout` shows bit 7 (the MSB) of the enhancement word while `enh_mode_n` is 0, so the word can be read back serially. While `enh_mode_n` is 1, `dout` is 0.
- R9: A synchronous active-low reset clears the primary, secondary and enhancement words to zero. During reset the synchronizers load the idle levels: `load_n`=1, `enh_mode_n`=1, and all other pins 0.
- R10: When a serial clock edge and a load-strobe rise land in the same cycle, the secondary word takes the primary word as it was before that cycle. The primary word does not take the bit. An enhancement shift in that same cycle still happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_data | input | 1 | Serial data, MSB first |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its rising edge |
| load_n | input | 1 | Load strobe; primary shifts while low, copy to secondary on rise |
| enh_wr | input | 1 | Write select: 0 = primary word, 1 = enhancement word |
| freq_sel | input | 1 | 1 = primary word on `div_word`, 0 = secondary word |
| enh_mode_n | input | 1 | Enhancement mode enable, active low |
| div_word | output | 20 | Divider-setting word |
| enh_bits | output | 8 | Gated enhancement word |
| dout | output | 1 | Serial read-back of the enhancement MSB |

## Verification
Two functions can fall in the same cycle: a shift caused by a serial clock edge and the primary-to-secondary copy caused by a load-strobe rise. The bench provokes this by raising `ser_clk` and `load_n` on the same system clock edge. It does this once with the write select high, where the enhancement word must shift and the copy must still happen. It does it again with the write select low, where the primary word must keep its value and the secondary word must receive the pre-edge value. A behavioural queue-based model predicts every output on every clock. Targeted checks then read back the secondary word, the primary word and the enhancement word through `freq_sel` and `enh_mode_n`.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  // bit positions inside the synchronized pin bundle
  localparam int unsigned PIN_COUNT = 6;
  localparam int unsigned PIN_DATA  = 5;
  localparam int unsigned PIN_SCLK  = 4;
  localparam int unsigned PIN_LOAD  = 3;
  localparam int unsigned PIN_WR    = 2;
  localparam int unsigned PIN_FSEL  = 1;
  localparam int unsigned PIN_MODE  = 0;
  // idle (reset) levels: strobe high, enhancement mode off, rest low
  localparam logic [PIN_COUNT-1:0] PIN_IDLE = 6'b001001;

  typedef enum logic {TGT_PRIMARY = 1'b0, TGT_ENHANCE = 1'b1} shift_target_e;
endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
  parameter int unsigned     W       = 6,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= din;
      for (int i = 1; i <= STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign lvl  = st[STAGES-1];
  assign rise = st[STAGES-1] & ~st[STAGES];
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= bit_in;
      end
    end else begin : g_multi
      // MSB-first: newest bit enters at bit 0, oldest leaves at the MSB
      always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {q[W-2:0], bit_in};
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_hold_reg.sv
module cfg_hold_reg #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/cfg_out_stage.sv
module cfg_out_stage #(
  parameter int unsigned PW = 20,
  parameter int unsigned EW = 8
) (
  input  logic [PW-1:0] prim_q,
  input  logic [PW-1:0] sec_q,
  input  logic [EW-1:0] enh_q,
  input  logic          sel_prim,
  input  logic          enh_off,
  output logic [PW-1:0] div_word,
  output logic [EW-1:0] enh_bits,
  output logic          dout
);
  assign div_word = sel_prim ? prim_q : sec_q;

  // each enhancement bit is forced inactive outside enhancement mode
  for (genvar i = 0; i < EW; i++) begin : g_gate
    assign enh_bits[i] = enh_q[i] & ~enh_off;
  end

  assign dout = enh_q[EW-1] & ~enh_off;
endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned PRIM_W      = 20,
  parameter int unsigned ENH_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_clk,
  input  logic              load_n,
  input  logic              enh_wr,
  input  logic              freq_sel,
  input  logic              enh_mode_n,
  output logic [PRIM_W-1:0] div_word,
  output logic [ENH_W-1:0]  enh_bits,
  output logic              dout
);
  logic [PIN_COUNT-1:0] pins_raw, pins_lvl, pins_rise;
  logic [PRIM_W-1:0]    prim_q, sec_q;
  logic [ENH_W-1:0]     enh_q;
  logic                 sclk_rise, ld_rise, ld_lvl, wr_enh, enh_off, sel_prim, bit_s;
  logic                 prim_shift, enh_shift;
  shift_target_e        target;
  logic                 unused_sync;

  assign pins_raw = {ser_data, ser_clk, load_n, enh_wr, freq_sel, enh_mode_n};

  cfg_pin_sync #(
    .W(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pins_raw), .lvl(pins_lvl), .rise(pins_rise)
  );

  assign sclk_rise = pins_rise[PIN_SCLK];
  assign ld_rise   = pins_rise[PIN_LOAD];
  assign ld_lvl    = pins_lvl[PIN_LOAD];
  assign wr_enh    = pins_lvl[PIN_WR];
  assign enh_off   = pins_lvl[PIN_MODE];
  assign sel_prim  = pins_lvl[PIN_FSEL];
  assign bit_s     = pins_lvl[PIN_DATA];
  assign unused_sync = ^{pins_rise[PIN_DATA], pins_rise[PIN_WR], pins_rise[PIN_FSEL],
                         pins_rise[PIN_MODE], pins_lvl[PIN_SCLK]};

  assign target     = wr_enh ? TGT_ENHANCE : TGT_PRIMARY;
  assign prim_shift = sclk_rise && (target == TGT_PRIMARY) && !ld_lvl;
  assign enh_shift  = sclk_rise && (target == TGT_ENHANCE);

  cfg_shift_reg #(.W(PRIM_W)) u_prim (
    .clk(clk), .rst_n(rst_n), .shift_en(prim_shift), .bit_in(bit_s), .q(prim_q)
  );

  cfg_shift_reg #(.W(ENH_W)) u_enh (
    .clk(clk), .rst_n(rst_n), .shift_en(enh_shift), .bit_in(bit_s), .q(enh_q)
  );

  cfg_hold_reg #(.W(PRIM_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .load(ld_rise), .d(prim_q), .q(sec_q)
  );

  cfg_out_stage #(.PW(PRIM_W), .EW(ENH_W)) u_out (
    .prim_q(prim_q), .sec_q(sec_q), .enh_q(enh_q), .sel_prim(sel_prim),
    .enh_off(enh_off), .div_word(div_word), .enh_bits(enh_bits), .dout(dout)
  );
endmodule

// File: rtl/synth_cfg_port_chk.sv
module synth_cfg_port_chk #(
  parameter int unsigned PW = 20,
  parameter int unsigned EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sclk_rise,
  input logic          ld_rise,
  input logic          ld_lvl,
  input logic          wr_enh,
  input logic          enh_off,
  input logic [PW-1:0] prim_q,
  input logic [PW-1:0] sec_q,
  input logic [EW-1:0] enh_q,
  input logic [EW-1:0] enh_bits,
  input logic          dout
);
  // R2
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> ($stable(prim_q) && $stable(enh_q)));
  // R3
  prim_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enh |=> $stable(prim_q));
  // R3
  enh_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enh |=> $stable(enh_q));
  // R4
  strobe_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lvl |=> $stable(prim_q));
  // R5
  copy_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rise |=> (sec_q == $past(prim_q)));
  // R5
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> $stable(sec_q));
  // R7
  enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_off |-> (enh_bits == '0));
  // R8
  dout_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enh_off |-> !dout);
  // R8
  dout_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_off |-> (dout == enh_q[EW-1]));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (prim_q == '0 && sec_q == '0 && enh_q == '0));
endmodule

bind synth_cfg_port synth_cfg_port_chk #(.PW(PRIM_W), .EW(ENH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .ld_rise(ld_rise),
  .ld_lvl(ld_lvl), .wr_enh(wr_enh), .enh_off(enh_off), .prim_q(prim_q),
  .sec_q(sec_q), .enh_q(enh_q), .enh_bits(enh_bits), .dout(dout)
);

// File: tb/synth_cfg_port_test.sv
module synth_cfg_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_data = 1'b0, ser_clk = 1'b0, load_n = 1'b1, enh_wr = 1'b0;
  logic        freq_sel = 1'b0, enh_mode_n = 1'b1;
  logic [19:0] div_word;
  logic [7:0]  enh_bits;
  logic        dout;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  synth_cfg_port uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .load_n(load_n), .enh_wr(enh_wr), .freq_sel(freq_sel), .enh_mode_n(enh_mode_n),
    .div_word(div_word), .enh_bits(enh_bits), .dout(dout)
  );

  // ---------------- behavioural reference model ----------------
  // pin bundle: {data, sclk, load_n, wr, fsel, mode_n}
  localparam logic [5:0] IDLE = 6'b001001;
  logic [5:0]  hist [$];
  logic [19:0] m_prim = '0, m_sec = '0;
  logic [7:0]  m_enh = '0;

  initial hist = '{IDLE, IDLE, IDLE};

  always @(posedge clk) begin
    logic [5:0] cur, prev;
    started = 1;
    if (!rst_n) begin
      m_prim = '0; m_sec = '0; m_enh = '0;
      hist = '{IDLE, IDLE, IDLE};
    end else begin
      cur  = hist[1];
      prev = hist[2];
      if (cur[3] && !prev[3]) m_sec = m_prim;
      if (cur[4] && !prev[4]) begin
        if (cur[2])       m_enh  = {m_enh[6:0], cur[5]};
        else if (!cur[3]) m_prim = {m_prim[18:0], cur[5]};
      end
      hist.push_front({ser_data, ser_clk, load_n, enh_wr, freq_sel, enh_mode_n});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    logic [19:0] e_div;
    logic [7:0]  e_enh;
    logic        e_do;
    if (started && !done) begin
      e_div = hist[1][1] ? m_prim : m_sec;
      e_enh = hist[1][0] ? 8'h00 : m_enh;
      e_do  = hist[1][0] ? 1'b0 : m_enh[7];
      checks += 3;
      if (div_word !== e_div) begin
        errors++; $display("FAIL R6 model div_word got %h exp %h at %0t", div_word, e_div, $time);
      end
      if (enh_bits !== e_enh) begin
        errors++; $display("FAIL R7 model enh_bits got %h exp %h at %0t", enh_bits, e_enh, $time);
      end
      if (dout !== e_do) begin
        errors++; $display("FAIL R8 model dout got %b exp %b at %0t", dout, e_do, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data = b; step(3);
    ser_clk = 1'b1; step(3);
    ser_clk = 1'b0; step(1);
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    step(4);
  endtask

  localparam logic [19:0] P1 = 20'hA5C3E;
  localparam logic [19:0] P2 = 20'h1F0A7;
  localparam logic [19:0] P3 = 20'h3C5A1;

  // ---------------- stimulus ----------------
  initial begin
    step(4);
    rst_n = 1'b1;
    step(4);
    // R9 reset state
    chk("R9 div_word after reset", {12'h0, div_word}, 32'h0);
    chk("R9 enh_bits after reset", {24'h0, enh_bits}, 32'h0);
    chk("R9 dout after reset", {31'h0, dout}, 32'h0);

    // R1 R2: four bits into primary
    freq_sel = 1'b1; load_n = 1'b0; step(4);
    send_word(32'hB, 4);
    chk("R2 four bits captured", {12'h0, div_word}, 32'hB);
    send_word({12'h0, P1}, 20);
    chk("R1 MSB-first 20-bit word", {12'h0, div_word}, {12'h0, P1});

    // R5: strobe rise copies, R6 view secondary
    load_n = 1'b1; step(4);
    freq_sel = 1'b0; step(4);
    chk("R5 secondary took primary", {12'h0, div_word}, {12'h0, P1});

    // R4: shifting with strobe high leaves primary alone
    freq_sel = 1'b1; step(4);
    send_word(32'hF, 4);
    chk("R4 primary held while strobe high", {12'h0, div_word}, {12'h0, P1});

    // R6: different primary and secondary
    load_n = 1'b0; step(4);
    send_word({12'h0, P2}, 20);
    chk("R6 freq_sel=1 shows primary", {12'h0, div_word}, {12'h0, P2});
    freq_sel = 1'b0; step(4);
    chk("R6 freq_sel=0 shows secondary", {12'h0, div_word}, {12'h0, P1});

    // R3 R7 R8: enhancement word
    enh_wr = 1'b1; step(4);
    send_word(32'h96, 8);
    chk("R7 enh_bits gated off", {24'h0, enh_bits}, 32'h0);
    chk("R8 dout low outside mode", {31'h0, dout}, 32'h0);
    freq_sel = 1'b1; step(4);
    chk("R3 primary untouched by enh writes", {12'h0, div_word}, {12'h0, P2});
    enh_mode_n = 1'b0; step(4);
    chk("R3 enhancement word loaded", {24'h0, enh_bits}, 32'h96);
    chk("R8 dout shows MSB", {31'h0, dout}, 32'h1);
    send_word(32'h0, 1);
    chk("R8 dout serial readback", {31'h0, dout}, 32'h0);
    chk("R1 enh shift by one", {24'h0, enh_bits}, 32'h2C);

    // R10: coincident edges with enhancement target
    ser_data = 1'b1; step(3);
    ser_clk = 1'b1; load_n = 1'b1; step(3);
    ser_clk = 1'b0; step(4);
    chk("R10 enh shift alongside copy", {24'h0, enh_bits}, 32'h59);
    freq_sel = 1'b0; step(4);
    chk("R10 copy alongside enh shift", {12'h0, div_word}, {12'h0, P2});

    // R10: coincident edges with primary target
    enh_wr = 1'b0; load_n = 1'b0; freq_sel = 1'b1; step(4);
    send_word({12'h0, P3}, 20);
    chk("R1 third word", {12'h0, div_word}, {12'h0, P3});
    ser_data = 1'b0; step(3);
    ser_clk = 1'b1; load_n = 1'b1; step(3);
    ser_clk = 1'b0; step(4);
    chk("R10 primary skips bit on strobe rise", {12'h0, div_word}, {12'h0, P3});
    freq_sel = 1'b0; step(4);
    chk("R10 secondary takes pre-edge word", {12'h0, div_word}, {12'h0, P3});

    // R9: mid-run reset
    rst_n = 1'b0; step(3);
    rst_n = 1'b1; step(4);
    chk("R9 secondary cleared", {12'h0, div_word}, 32'h0);
    freq_sel = 1'b1; step(4);
    chk("R9 primary cleared", {12'h0, div_word}, 32'h0);
    chk("R9 enhancement cleared", {24'h0, enh_bits}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule